// File: doc/BRIEF.md
# Serial Flash Status Register Emulator

This block stands in for the status register of a serial flash memory inside an SPI target. It holds a 24-bit status word. The host reads that word one byte at a time, and the selected byte is shifted out on the serial data output. Two strobes change the write-enable latch (status bit 1) straight from the serial-clock domain. A third strobe sets the busy flag (status bit 0). Opcode decoding happens upstream. The decoder only presents a byte-select code once the opcode byte has been received, and it pulses the latch strobes for the write-enable and write-disable commands.

System software can replace the whole word from its own clock domain with a one-cycle write strobe. The new value does not reach the host at once. It is parked in a holding register. It is committed only at the start of the transaction that follows the next complete host transaction. As a result, the first status read after a software write still sees the old value, and later reads see the new one.

Top module: `flash_status_emu`

## Requirements
- R1: After reset, every status byte reads as 0x00 and the serial output is 0.
- R2: Byte-select code 1 returns status bits [7:0], code 2 returns bits [15:8], and code 3 returns bits [23:16]. These correspond to host opcodes 0x05, 0x35 and 0x15.
- R3: A selected byte is sent most significant bit first. The output changes on the falling serial-clock edge. The byte is repeated for as long as chip-select stays low.
- R4: A write-enable set strobe sampled on a rising serial-clock edge makes status bit 1 read as 1 afterwards.
- R5: A write-enable clear strobe makes status bit 1 read as 0 afterwards.
- R6: When the set and clear strobes arrive in the same cycle, clear wins.
- R7: A busy-set strobe makes status bit 0 read as 1 afterwards.
- R8: A software write is invisible to the first host transaction after it. It becomes visible from the transaction after that one.
- R9: When a pending software value is committed, on the first rising edge of a transaction, it overrides any latch or busy strobe on that same edge.
- R10: The serial output stays 0 while byte-select code 0 is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock for software writes |
| sys_rst_i | input | 1 | Synchronous active-high reset, system domain |
| sw_wr_i | input | 1 | One-cycle software write strobe |
| sw_data_i | input | 24 | Software status value |
| sck_i | input | 1 | Serial clock, runs only while chip-select is low |
| sck_rst_i | input | 1 | Synchronous active-high reset, serial domain |
| cs_n_i | input | 1 | Chip-select, active low |
| wel_set_i | input | 1 | Set write-enable latch strobe |
| wel_clr_i | input | 1 | Clear write-enable latch strobe |
| busy_set_i | input | 1 | Set busy flag strobe |
| rd_sel_i | input | 2 | Byte-select code (0 none, 1..3 byte) |
| sdo_o | output | 1 | Serial data output |

## Verification
The hardest case is a commit landing on the same edge as a latch strobe. That edge exists only as the first rising edge of the second transaction after a software write. To reach it, the stimulus writes a value, runs one full read transaction so the pending request is observed, and then pulses the set strobe in the very first opcode cycle of the next transaction. A read-back in that same transaction shows whether the committed word or the strobe won. A later transaction with a late set strobe confirms that the latch works normally again.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
  localparam int SEL_NONE = 0;
endpackage

// File: rtl/fse_sys_hold.sv
`timescale 1ns/1ps
module fse_sys_hold #(
  parameter int W = 24
) (
  input  logic         sys_clk_i,
  input  logic         sys_rst_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] pend_data_o,
  output logic         req_tog_o
);
  always_ff @(posedge sys_clk_i) begin
    if (sys_rst_i) begin
      pend_data_o <= '0;
      req_tog_o   <= 1'b0;
    end else if (wr_en_i) begin
      pend_data_o <= wr_data_i;
      req_tog_o   <= ~req_tog_o;
    end
  end

  // R8
  sw_req_flip_chk: assert property (@(posedge sys_clk_i) disable iff (sys_rst_i)
    wr_en_i |=> (req_tog_o != $past(req_tog_o)) && (pend_data_o == $past(wr_data_i)));
endmodule

// File: rtl/fse_status_core.sv
`timescale 1ns/1ps
module fse_status_core
  import flash_status_pkg::*;
#(
  parameter int           W           = 24,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] RESET_VAL   = '0
) (
  input  logic         sck_i,
  input  logic         rst_i,
  input  logic         cs_n_i,
  input  logic         we_set_i,
  input  logic         we_clr_i,
  input  logic         busy_set_i,
  input  logic [W-1:0] pend_data_i,
  input  logic         req_tog_i,
  output logic [W-1:0] status_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;
  logic                   applied_q;
  logic                   in_txn;
  logic                   commit;
  logic [W-1:0]           status_q;

  // first edge of a transaction: flag cleared while chip-select is high
  always_ff @(posedge sck_i or posedge cs_n_i) begin
    if (cs_n_i) in_txn <= 1'b0;
    else        in_txn <= 1'b1;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge sck_i) begin
        if (rst_i)       sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= req_tog_i;
        else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // seen_q holds the request state observed on the last edge of the previous transaction
  assign commit = !in_txn && (seen_q != applied_q);

  always_ff @(posedge sck_i) begin
    if (rst_i) begin
      seen_q    <= 1'b0;
      applied_q <= 1'b0;
      status_q  <= RESET_VAL;
    end else begin
      seen_q <= sync_q[SYNC_STAGES-1];
      if (commit) begin
        applied_q <= seen_q;
        status_q  <= pend_data_i;
      end else begin
        if (we_clr_i)      status_q[WEL_BIT] <= 1'b0;
        else if (we_set_i) status_q[WEL_BIT] <= 1'b1;
        if (busy_set_i)    status_q[BUSY_BIT] <= 1'b1;
      end
    end
  end

  assign status_o = status_q;

  // R4
  wel_set_chk: assert property (@(posedge sck_i) disable iff (rst_i)
    (we_set_i && !we_clr_i && !commit) |=> status_q[WEL_BIT]);
  // R6
  wel_clr_wins_chk: assert property (@(posedge sck_i) disable iff (rst_i)
    (we_clr_i && !commit) |=> !status_q[WEL_BIT]);
  // R7
  busy_set_chk: assert property (@(posedge sck_i) disable iff (rst_i)
    (busy_set_i && !commit) |=> status_q[BUSY_BIT]);
  // R9
  commit_override_chk: assert property (@(posedge sck_i) disable iff (rst_i)
    commit |=> status_q == $past(pend_data_i));
endmodule

// File: rtl/fse_byte_shift.sv
`timescale 1ns/1ps
module fse_byte_shift
  import flash_status_pkg::*;
#(
  parameter int W      = 24,
  parameter int BYTE_W = 8,
  localparam int NBYTES = W / BYTE_W,
  localparam int SEL_W  = $clog2(NBYTES + 1),
  localparam int IDX_W  = $clog2(BYTE_W)
) (
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic [W-1:0]     status_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic             sdo_o
);
  logic [BYTE_W-1:0] byte_arr [NBYTES];
  logic [BYTE_W-1:0] pick;
  logic [BYTE_W-1:0] snap;
  logic [IDX_W-1:0]  idx;
  logic              active;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
      assign byte_arr[b] = status_i[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_sel_i == SEL_W'(b + 1)) pick = byte_arr[b];
  end

  always_ff @(negedge sck_i or posedge cs_n_i) begin
    if (cs_n_i) begin
      active <= 1'b0;
      snap   <= '0;
      idx    <= '0;
      sdo_o  <= 1'b0;
    end else if (rd_sel_i != SEL_W'(SEL_NONE)) begin
      if (!active) begin
        active <= 1'b1;
        snap   <= pick;
        sdo_o  <= pick[BYTE_W-1];
        idx    <= IDX_W'(BYTE_W - 2);
      end else begin
        sdo_o <= snap[idx];
        idx   <= (idx == '0) ? IDX_W'(BYTE_W - 1) : idx - 1'b1;
      end
    end else begin
      sdo_o <= 1'b0;
    end
  end

  // R10
  idle_low_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
    !active |-> !sdo_o);
  // R3
  snap_hold_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
    (active && $past(active)) |-> $stable(snap));
endmodule

// File: rtl/flash_status_emu.sv
`timescale 1ns/1ps
module flash_status_emu #(
  parameter int            W           = 24,
  parameter int            BYTE_W      = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [W-1:0]  RESET_VAL   = '0,
  localparam int           SEL_W       = $clog2(W / BYTE_W + 1)
) (
  input  logic             sys_clk_i,
  input  logic             sys_rst_i,
  input  logic             sw_wr_i,
  input  logic [W-1:0]     sw_data_i,
  input  logic             sck_i,
  input  logic             sck_rst_i,
  input  logic             cs_n_i,
  input  logic             wel_set_i,
  input  logic             wel_clr_i,
  input  logic             busy_set_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic             sdo_o
);
  logic [W-1:0] pend_data;
  logic         req_tog;
  logic [W-1:0] status;

  fse_sys_hold #(.W(W)) u_hold (
    .sys_clk_i  (sys_clk_i),
    .sys_rst_i  (sys_rst_i),
    .wr_en_i    (sw_wr_i),
    .wr_data_i  (sw_data_i),
    .pend_data_o(pend_data),
    .req_tog_o  (req_tog)
  );

  fse_status_core #(.W(W), .SYNC_STAGES(SYNC_STAGES), .RESET_VAL(RESET_VAL)) u_core (
    .sck_i      (sck_i),
    .rst_i      (sck_rst_i),
    .cs_n_i     (cs_n_i),
    .we_set_i   (wel_set_i),
    .we_clr_i   (wel_clr_i),
    .busy_set_i (busy_set_i),
    .pend_data_i(pend_data),
    .req_tog_i  (req_tog),
    .status_o   (status)
  );

  fse_byte_shift #(.W(W), .BYTE_W(BYTE_W)) u_shift (
    .sck_i   (sck_i),
    .cs_n_i  (cs_n_i),
    .status_i(status),
    .rd_sel_i(rd_sel_i),
    .sdo_o   (sdo_o)
  );
endmodule

// File: tb/flash_status_emu_tb.sv
`timescale 1ns/1ps
module flash_status_emu_tb;
  logic        sys_clk = 1'b0;
  logic        sys_rst = 1'b1;
  logic        sw_wr = 1'b0;
  logic [23:0] sw_data = '0;
  logic        sck = 1'b0;
  logic        sck_rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        wel_set = 1'b0, wel_clr = 1'b0, busy_set = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic        sdo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  // bench model
  logic [23:0] m_stat = '0, m_pend = '0;
  bit m_pend_valid = 0, m_armed = 0;

  always #2.5 sys_clk = ~sys_clk;

  flash_status_emu u_dut (
    .sys_clk_i(sys_clk), .sys_rst_i(sys_rst), .sw_wr_i(sw_wr), .sw_data_i(sw_data),
    .sck_i(sck), .sck_rst_i(sck_rst), .cs_n_i(cs_n),
    .wel_set_i(wel_set), .wel_clr_i(wel_clr), .busy_set_i(busy_set),
    .rd_sel_i(rd_sel), .sdo_o(sdo)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // strobe cycle index -1 means none
  task automatic txn(input string tag, input logic [1:0] sel, input int nbytes,
                     input int set_at, input int clr_at, input int busy_at);
    bit committed = 0;
    if (m_armed) begin m_stat = m_pend; m_armed = 0; committed = 1; end
    if (clr_at >= 0 && !(committed && clr_at == 0)) m_stat[1] = 1'b0;
    else if (set_at >= 0 && !(committed && set_at == 0)) m_stat[1] = 1'b1;
    if (busy_at >= 0 && !(committed && busy_at == 0)) m_stat[0] = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      exp_q.push_back(sel == 2'd0 ? 8'h00 : m_stat[(sel-1)*8 +: 8]);
      tag_q.push_back(tag);
    end
    cs_n = 1'b0; #5;
    for (int i = 0; i < 8; i++) begin
      wel_set = (i == set_at); wel_clr = (i == clr_at); busy_set = (i == busy_at);
      #5 sck = 1'b1;
      #5 wel_set = 0; wel_clr = 0; busy_set = 0;
      if (i == 7) rd_sel = sel;
      #5 sck = 1'b0;
      #5;
    end
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] rx = '0;
      for (int k = 0; k < 8; k++) begin
        rx = {rx[6:0], sdo};
        #5 sck = 1'b1;
        #10 sck = 1'b0;
        #5;
      end
      got_q.push_back(rx);
    end
    rd_sel = 2'd0; cs_n = 1'b1; #20;
    if (m_pend_valid) begin m_armed = 1; m_pend_valid = 0; end
  endtask

  task automatic sw_write(input logic [23:0] d);
    @(negedge sys_clk); sw_wr = 1'b1; sw_data = d;
    @(negedge sys_clk); sw_wr = 1'b0;
    repeat (4) @(negedge sys_clk);
    m_pend = d; m_pend_valid = 1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge sys_clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) begin #10 sck = 1'b1; #10 sck = 1'b0; end
    @(negedge sys_clk); sys_rst = 1'b0;
    sck_rst = 1'b0; #20;
    // R1 reset state of the output
    check("R1 sdo", {7'b0, sdo}, 8'h00);
    txn("R1/R2 byte1", 2'd1, 1, -1, -1, -1);
    txn("R1/R2 byte2", 2'd2, 1, -1, -1, -1);
    txn("R1/R2 byte3", 2'd3, 1, -1, -1, -1);
    // R7
    txn("R7 busy", 2'd1, 1, -1, -1, 3);
    // R8: first read after write sees old value, next sees new
    sw_write(24'h81_42_18);
    txn("R8 old", 2'd1, 1, -1, -1, -1);
    txn("R8/R2 mid", 2'd2, 1, -1, -1, -1);
    txn("R2 high", 2'd3, 1, -1, -1, -1);
    // R3 MSB first, repeat while selected
    txn("R3 repeat", 2'd1, 2, -1, -1, -1);
    // R4 R5 R6
    txn("R4 set", 2'd1, 1, 4, -1, -1);
    txn("R5 clr", 2'd1, 1, -1, 2, -1);
    txn("R4 set again", 2'd1, 1, 6, -1, -1);
    txn("R6 both", 2'd1, 1, 5, 5, -1);
    // R9 commit overrides strobe on first edge
    sw_write(24'h00_00_F0);
    txn("R9 pre", 2'd1, 1, 7, -1, -1);
    txn("R9 override", 2'd1, 1, 0, -1, 0);
    txn("R9 after", 2'd1, 1, 5, -1, -1);
    // R10 no byte selected
    txn("R10 idle", 2'd0, 1, -1, -1, -1);
    repeat (10) @(posedge sys_clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule